// File: doc/BRIEF.md
# Multiplier-resolution watchdog

This block is a watchdog timer controlled through a single byte-wide control register on a simple strobe-based register port. The control byte holds three fields. A 5-bit multiplier and a 2-bit resolution code select a timeout counted in periods of an external 16 Hz tick. A steering bit decides what happens when the count runs out. The timeout in ticks is the multiplier shifted left by twice the resolution code. A multiplier of zero disables the timer.

Software keeps the watchdog alive by accessing the control register. A write loads a new setting, clears the sticky expiry flag and restarts the count. A read returns the setting and restarts the count with it. On expiry the flag is set. Depending on the steering bit, the block then either pulses a system reset request, after clearing the control register and one bit of an auxiliary register, or pulses an interrupt. A small flags register and the auxiliary byte sit beside the control register on the same port. The 16 Hz tick is generated elsewhere.

Top module: `mrwd_watchdog`

## Requirements
- R1: After a synchronous active-low reset, the control, flags and auxiliary registers read 0x00, `wd_flag`, `irq` and `sys_reset_req` are low, and ticks cause no expiry until the control register is written.
- R2: The control register at 0x1FF7 holds the resolution code in bits [1:0], the multiplier in bits [6:2] and the steering bit in bit 7. Expiry happens on exactly the (multiplier << 2*resolution)-th tick after the most recent restart, and never earlier.
- R3: Writing the control register clears the expiry flag and restarts the countdown from the newly written setting.
- R4: Reading the control register returns its stored value and restarts the countdown with that setting. A read leaves the expiry flag unchanged.
- R5: On expiry, bit 7 of the flags register at 0x1FF0 and the `wd_flag` output go high and stay high until the next control write. The other flags bits read 0. Writes to the flags register have no effect.
- R6: When the steering bit is 1 at expiry, the control register becomes 0x00 and bit 6 of the auxiliary register at 0x1FFC is cleared, with its other bits kept. `sys_reset_req` is high for exactly one cycle and `irq` stays low.
- R7: When the steering bit is 0 at expiry, `irq` is high for exactly one cycle and `sys_reset_req` stays low. The control register keeps its value, and there is no further expiry until the next restart.
- R8: A multiplier of 0 disables the watchdog: no number of ticks causes an expiry.
- R9: The auxiliary register reads back the last byte written to it. A read from any address other than the three registers returns 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| rd_en | input | 1 | Register read strobe, one cycle per read |
| addr | input | ADDR_W (13) | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| tick_16hz | input | 1 | One-cycle pulse at each 1/16 second |
| wd_flag | output | 1 | Sticky expiry flag |
| sys_reset_req | output | 1 | One-cycle system reset request |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench builds the block with its default parameters: a 13-bit address and the control, flags and auxiliary registers at 0x1FF7, 0x1FF0 and 0x1FFC. It keeps the package field widths of a 5-bit multiplier and a 2-bit resolution code. With these widths the longest timeout is 1984 ticks, so the bench drives it in full and checks the exact expiring tick at the top of the range. The short settings, from 3 to 32 ticks, let it cover every routing path, a restart just before expiry and the one-shot behaviour.

// File: rtl/mrwd_pkg.sv
// Shared constants, field layout and types of the multiplier-resolution watchdog.
// Assumes an 8-bit register port; the control byte layout is fixed by the
// struct below (steer at the top, multiplier in the middle, resolution low).
package mrwd_pkg;
    localparam int DATA_W       = 8;
    localparam int RES_W        = 2;
    localparam int MULT_W       = 5;
    localparam int NUM_RES      = 1 << RES_W;
    localparam int MAX_SHIFT    = 2 * (NUM_RES - 1);
    localparam int CNT_W        = MULT_W + MAX_SHIFT;
    localparam int FLAG_BIT     = 7;
    localparam int AUX_HOLD_BIT = 6;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef struct packed {
        logic              steer;
        logic [MULT_W-1:0] mult;
        logic [RES_W-1:0]  res;
    } ctrl_t;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_FLAG = 2'd2,
        SEL_AUX  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/mrwd_period.sv
// Converts a control setting into a timeout length in ticks.
// One shifted copy of the multiplier is built per resolution code and the
// code selects among them; assumes ticks fit in CNT_W bits (true by construction).
module mrwd_period
    import mrwd_pkg::*;
(
    input  ctrl_t cfg,
    output cnt_t  ticks
);
    cnt_t cand [NUM_RES];

    // One candidate per resolution code: multiplier times 4^code.
    for (genvar g = 0; g < NUM_RES; g++) begin : g_res
        assign cand[g] = cnt_t'(cfg.mult) << (2 * g);
    end

    // Pick the candidate named by the resolution field.
    assign ticks = cand[cfg.res];
endmodule

// File: rtl/mrwd_countdown.sv
// Tick-driven down counter of the watchdog.
// A restart loads a fresh period; each tick decrements a nonzero count; the
// tick that moves the count from 1 to 0 is the expiry. A zero count is idle,
// so a zero period (multiplier 0) never expires. Restart has priority over tick.
module mrwd_countdown
    import mrwd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic restart,
    input  cnt_t load_ticks,
    output logic expire
);
    cnt_t cnt_q;

    // Load on restart, otherwise count ticks down to zero and stop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (restart)
            cnt_q <= load_ticks;
        else if (tick && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    // Expiry is the last tick of a running count that no restart overrides.
    assign expire = tick && !restart && (cnt_q == cnt_t'(1));

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !restart && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1))
        else $error("count did not step on a tick");

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !restart) |=> $stable(cnt_q))
        else $error("count moved without tick or restart");

    p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt_q == $past(load_ticks)))
        else $error("restart did not load the period");
endmodule

// File: rtl/mrwd_expiry_route.sv
// Steers an expiry either to a one-cycle reset request or a one-cycle IRQ.
// Assumes expire is itself a single-cycle strobe. take_reset is combinational
// so the register block can clear its state on the same edge.
module mrwd_expiry_route (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic steer,
    output logic take_reset,
    output logic irq_q,
    output logic rst_req_q
);
    logic take_irq;

    // Split the expiry strobe by the steering bit.
    always_comb begin
        take_reset = expire && steer;
        take_irq   = expire && !steer;
    end

    // Register both pulses so each lasts exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q     <= 1'b0;
            rst_req_q <= 1'b0;
        end else begin
            irq_q     <= take_irq;
            rst_req_q <= take_reset;
        end
    end

    p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q)
        else $error("irq longer than one cycle");

    p_rst_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_q |=> !rst_req_q)
        else $error("reset request longer than one cycle");

    p_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_q && rst_req_q))
        else $error("irq and reset request together");
endmodule

// File: rtl/mrwd_decode_regs.sv
// Address decode and storage for the control, flags and auxiliary registers.
// Assumes at most one strobe matters per cycle (write wins over read). An
// access to the control register produces the restart and the period source.
module mrwd_decode_regs
    import mrwd_pkg::*;
#(
    parameter int                ADDR_W    = 13,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 13'h1FF7,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = 13'h1FF0,
    parameter logic [ADDR_W-1:0] AUX_ADDR  = 13'h1FFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  byte_t             wdata,
    input  logic              expire,
    input  logic              take_reset,
    output byte_t             rdata,
    output ctrl_t             ctrl,
    output ctrl_t             load_cfg,
    output logic              restart,
    output logic              flag
);
    reg_sel_e sel;
    logic     ctrl_wr;
    logic     aux_wr;
    ctrl_t    ctrl_q;
    byte_t    aux_q;
    logic     flag_q;

    // Map the address onto one of the register slots.
    always_comb begin
        if (addr == CTRL_ADDR)      sel = SEL_CTRL;
        else if (addr == FLAG_ADDR) sel = SEL_FLAG;
        else if (addr == AUX_ADDR)  sel = SEL_AUX;
        else                        sel = SEL_NONE;
    end

    // Access strobes and the setting a restart should load.
    always_comb begin
        ctrl_wr  = wr_en && (sel == SEL_CTRL);
        aux_wr   = wr_en && (sel == SEL_AUX);
        restart  = (wr_en || rd_en) && (sel == SEL_CTRL);
        load_cfg = ctrl_wr ? ctrl_t'(wdata) : ctrl_q;
    end

    // Control register: software write, or cleared by a reset-steered expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (ctrl_wr)
            ctrl_q <= ctrl_t'(wdata);
        else if (take_reset)
            ctrl_q <= '0;
    end

    // Sticky expiry flag, cleared only by a control write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (ctrl_wr)
            flag_q <= 1'b0;
        else if (expire)
            flag_q <= 1'b1;
    end

    // Auxiliary byte: software write; one bit dropped on reset-steered expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            aux_q <= '0;
        else if (aux_wr)
            aux_q <= wdata;
        else if (take_reset)
            aux_q[AUX_HOLD_BIT] <= 1'b0;
    end

    // Read mux; unmapped addresses return all ones.
    always_comb begin
        unique case (sel)
            SEL_CTRL: rdata = byte_t'(ctrl_q);
            SEL_FLAG: rdata = byte_t'(flag_q) << FLAG_BIT;
            SEL_AUX:  rdata = aux_q;
            default:  rdata = '1;
        endcase
    end

    assign ctrl = ctrl_q;
    assign flag = flag_q;

    p_flag_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == CTRL_ADDR) |=> !flag_q)
        else $error("control write did not clear the flag");

    p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !(wr_en && addr == CTRL_ADDR)) |=> flag_q)
        else $error("flag dropped without a control write");

    p_aux_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (take_reset && !aux_wr) |=> (aux_q == ($past(aux_q) & ~(byte_t'(1) << AUX_HOLD_BIT))))
        else $error("aux bits other than the hold bit changed");
endmodule

// File: rtl/mrwd_watchdog.sv
// Top of the multiplier-resolution watchdog.
// Ties the register block, the period selector, the countdown and the expiry
// router together. Assumes tick_16hz is a one-cycle pulse synchronous to clk
// and that register strobes last one cycle per access.
module mrwd_watchdog
    import mrwd_pkg::*;
#(
    parameter int                ADDR_W    = 13,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 13'h1FF7,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = 13'h1FF0,
    parameter logic [ADDR_W-1:0] AUX_ADDR  = 13'h1FFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              tick_16hz,
    output logic              wd_flag,
    output logic              sys_reset_req,
    output logic              irq
);
    ctrl_t ctrl;
    ctrl_t load_cfg;
    cnt_t  load_ticks;
    logic  restart;
    logic  expire;
    logic  take_reset;

    mrwd_decode_regs #(
        .ADDR_W    (ADDR_W),
        .CTRL_ADDR (CTRL_ADDR),
        .FLAG_ADDR (FLAG_ADDR),
        .AUX_ADDR  (AUX_ADDR)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .addr       (addr),
        .wdata      (wdata),
        .expire     (expire),
        .take_reset (take_reset),
        .rdata      (rdata),
        .ctrl       (ctrl),
        .load_cfg   (load_cfg),
        .restart    (restart),
        .flag       (wd_flag)
    );

    mrwd_period u_period (
        .cfg   (load_cfg),
        .ticks (load_ticks)
    );

    mrwd_countdown u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick_16hz),
        .restart    (restart),
        .load_ticks (load_ticks),
        .expire     (expire)
    );

    mrwd_expiry_route u_route (
        .clk        (clk),
        .rst_n      (rst_n),
        .expire     (expire),
        .steer      (ctrl.steer),
        .take_reset (take_reset),
        .irq_q      (irq),
        .rst_req_q  (sys_reset_req)
    );

    p_flag_with_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq || sys_reset_req) |-> wd_flag)
        else $error("event output without flag");

    p_ctrl_cleared_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |-> (ctrl == '0))
        else $error("control not cleared on reset request");

    p_irq_keeps_ctrl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !ctrl.steer)
        else $error("irq raised while steering to reset");
endmodule

// File: tb/mrwd_watchdog_test.sv
// Scoreboard bench: driver tasks queue the expected expiry events, a monitor
// pops and compares each event the design produces; register reads are compared inline.
module mrwd_watchdog_test;
    localparam logic [12:0] A_CTRL = 13'h1FF7;
    localparam logic [12:0] A_FLAG = 13'h1FF0;
    localparam logic [12:0] A_AUX  = 13'h1FFC;
    localparam logic [12:0] A_NONE = 13'h0100;
    localparam int EV_IRQ = 1;
    localparam int EV_RST = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [12:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        tick_16hz = 1'b0;
    logic        wd_flag;
    logic        sys_reset_req;
    logic        irq;

    typedef struct { int kind; string tag; } exp_t;
    exp_t sb[$];
    int   checks = 0;
    int   fails  = 0;
    bit   done   = 0;

    always #5 clk = ~clk;

    mrwd_watchdog uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tick_16hz(tick_16hz), .wd_flag(wd_flag),
        .sys_reset_req(sys_reset_req), .irq(irq)
    );

    task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(logic [12:0] a, logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic reg_rd(logic [12:0] a, logic [7:0] exp, string tag);
        @(negedge clk); addr = a; rd_en = 1'b1;
        #1 check8(tag, rdata, exp);
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic ticks(int n);
        repeat (n) begin
            @(negedge clk); tick_16hz = 1'b1;
            @(negedge clk); tick_16hz = 1'b0;
        end
    endtask

    task automatic expect_event(int kind, string tag);
        exp_t e;
        e.kind = kind; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic drained(string tag);
        #2;
        checks++;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL %s: actual %0d pending events expected 0", tag, sb.size());
            sb.delete();
        end
    endtask

    // Monitor: every expiry pulse must match the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && (irq || sys_reset_req)) begin
            int kind;
            kind = (irq ? EV_IRQ : 0) + (sys_reset_req ? EV_RST : 0);
            checks++;
            if (sb.size() == 0) begin
                fails++;
                $display("FAIL R2: actual event %0d expected none", kind);
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (kind != e.kind) begin
                    fails++;
                    $display("FAIL %s: actual event %0d expected %0d", e.tag, kind, e.kind);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check8("R1", {5'b0, wd_flag, irq, sys_reset_req}, 8'h00);
        reg_rd(A_CTRL, 8'h00, "R1");
        reg_rd(A_FLAG, 8'h00, "R1");
        reg_rd(A_AUX,  8'h00, "R1");
        ticks(5);
        drained("R1");
        // R9: aux readback, unmapped read
        reg_wr(A_AUX, 8'hFF);
        reg_rd(A_AUX, 8'hFF, "R9");
        reg_rd(A_NONE, 8'hFF, "R9");
        // R5: flags write ignored
        reg_wr(A_FLAG, 8'h80);
        reg_rd(A_FLAG, 8'h00, "R5");
        // R2/R7: mult 3, res 0, steer 0 -> 3 ticks, irq
        reg_wr(A_CTRL, 8'h0C);
        ticks(2);
        drained("R2");
        expect_event(EV_IRQ, "R7");
        ticks(1);
        drained("R2");
        reg_rd(A_FLAG, 8'h80, "R5");
        check8("R5", {7'b0, wd_flag}, 8'h01);
        ticks(10);
        drained("R7");
        reg_rd(A_CTRL, 8'h0C, "R7");
        // R4: that read restarted the count without clearing the flag
        reg_rd(A_FLAG, 8'h80, "R4");
        ticks(2);
        drained("R4");
        expect_event(EV_IRQ, "R4");
        ticks(1);
        drained("R4");
        // R5: flags write still ignored while set
        reg_wr(A_FLAG, 8'h00);
        reg_rd(A_FLAG, 8'h80, "R5");
        // R3: mult 3, res 1 -> 12 ticks; rewrite just before expiry
        reg_wr(A_CTRL, 8'h0D);
        reg_rd(A_FLAG, 8'h00, "R3");
        ticks(11);
        reg_wr(A_CTRL, 8'h0D);
        ticks(11);
        drained("R3");
        expect_event(EV_IRQ, "R3");
        ticks(1);
        drained("R3");
        // R6: steer 1, mult 2, res 2 -> 32 ticks, reset request
        reg_wr(A_CTRL, 8'h8A);
        ticks(31);
        drained("R6");
        expect_event(EV_RST, "R6");
        ticks(1);
        drained("R6");
        reg_rd(A_CTRL, 8'h00, "R6");
        reg_rd(A_AUX,  8'hBF, "R6");
        reg_rd(A_FLAG, 8'h80, "R6");
        ticks(40);
        drained("R6");
        // R8: multiplier zero with the largest resolution never expires
        reg_wr(A_CTRL, 8'h03);
        reg_rd(A_FLAG, 8'h00, "R3");
        ticks(100);
        drained("R8");
        // R2: largest timeout, 31 << 6 = 1984 ticks
        reg_wr(A_CTRL, 8'h7F);
        ticks(1983);
        drained("R2");
        expect_event(EV_IRQ, "R2");
        ticks(1);
        drained("R2");
        repeat (3) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule